// File: doc/BRIEF.md
# Variable-Latency Execute Pipeline

This block is a small in-order integer core with five stages: fetch, decode, operand fetch, execute and write-back. Each stage handles one instruction per cycle, except execute. Execute is a single unit that is not pipelined. It keeps an instruction for one, three or six cycles, depending on the opcode. While execute is occupied, the operand-fetch, decode and fetch stages keep their contents. No bubble enters the front end until execute becomes free.

A dependent instruction picks up its operands as it enters execute. A value that the execute unit is finishing in the same cycle goes straight across to the dependent instruction. The register file also passes a write-back value through to a read in the same cycle. Between them, these two paths let a dependent instruction begin execute in the cycle after its producer's last execute cycle.

The surrounding logic fills the instruction memory and the register file through a valid/ready load port while the core is stopped. It then raises `run`. Each completed instruction produces a one-cycle retire strobe that carries the destination register and the value written. A free-running cycle counter gives a time base for these strobes.

Top module: `vlx_pipe`

## Requirements
- R1: An instruction with no hazard fetched in cycle c retires (ret_valid high) in cycle c+4. Fetch, decode, operand fetch and write-back take one cycle each.
- R2: Execute holds an instruction for 1 cycle for ADD and SUB, 3 cycles for MUL and 6 cycles for DIV. Younger instructions wait behind it in order, and none is lost or duplicated.
- R3: Instruction word fields: opcode in bits 15:13 (0 ADD, 1 SUB, 2 MUL, 3 DIV), destination in 10:8, first source in 6:4, second source in 2:0. The destination receives src1 op src2, truncated to XLEN bits. DIV is an unsigned quotient.
- R4: A DIV whose divisor is zero writes all ones.
- R5: A dependent instruction receives its producer's result without waiting for write-back. This holds both when the producer is in its last execute cycle and when the producer is in write-back. A chain of dependent ADDs retires one per cycle.
- R6: When several in-flight instructions write the source register, the youngest producer's value is used.
- R7: The sequence MUL R2,R0,R1; DIV R5,R3,R4; ADD R2,R5,R2; SUB R5,R2,R6 retires its last instruction 14 cycles after its first fetch cycle, so 15 cycles counted inclusively.
- R8: Each instruction raises ret_valid for exactly one cycle, in program order, with ret_rd and ret_data equal to its destination and result.
- R9: An instruction word with bit 15 set (opcode 4 to 7) stops fetch. Instructions already fetched before it complete. Nothing after it retires. `drained` then stays high until reset.
- R10: cycle_cnt is 0 while reset is applied and increases by one every clock after reset.
- R11: ld_ready is low whenever run is high or a write-back is in progress. A load offered while ld_ready is low has no effect. With ld_to_rf=1 a load writes register ld_addr[2:0]; with ld_to_rf=0 it writes instruction word ld_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears registers, PC, pipeline and counter |
| ld_valid | input | 1 | Load word offered; must stay high until accepted |
| ld_ready | output | 1 | Load accepted at this edge when ld_valid is also high |
| ld_to_rf | input | 1 | 1: load targets the register file; 0: load targets instruction memory |
| ld_addr | input | AW | Register index (low 3 bits) or instruction address |
| ld_data | input | XLEN | Load data (instruction uses low 16 bits) |
| run | input | 1 | Fetch enable |
| ret_valid | output | 1 | Retire strobe, one cycle per completed instruction |
| ret_rd | output | 3 | Destination register of the retiring instruction |
| ret_data | output | XLEN | Value written by the retiring instruction |
| cycle_cnt | output | CNT_W | Free-running cycle counter |
| drained | output | 1 | Fetch stopped and no instruction in flight |

## Verification
The bench targets the hand-off points where a wrong design would give the wrong value or the wrong timing. It builds a dependent chain in which one operand comes from the finishing execute result and the other from write-back. A design with either path missing would read a stale register and retire wrong sums. It writes one register twice in a row and then reads it. A design with the wrong bypass priority would return the older value. It checks the retire cycles for a mixed ADD/SUB/MUL/DIV stream and for the four-instruction reference sequence. A stage that fails to stall would lose or duplicate instructions, and a wrong latency would shift the retire cycles. It also checks a zero divisor, instructions placed after the halt word, and a register load offered while the core runs. The first would show an undefined quotient, the second would show extra retires, and the third would corrupt the value read by a later instruction.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

  localparam int IW   = 16;
  localparam int RW   = 3;
  localparam int NREG = 8;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_DIV = 3'd3;

  typedef struct packed {
    logic [2:0]    op;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
  } dec_t;

  function automatic dec_t decode(input logic [IW-1:0] w);
    dec_t d;
    d.op  = w[15:13];
    d.rd  = w[10:8];
    d.rs1 = w[6:4];
    d.rs2 = w[2:0];
    return d;
  endfunction

  // opcodes 4..7 end the program
  function automatic logic is_stop(input logic [IW-1:0] w);
    return w[15];
  endfunction

endpackage

// File: rtl/vlx_fetch.sv
module vlx_fetch import vlx_pkg::*; #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic          run,
  input  logic          accept,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  output logic          stopped
);

  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] pc;
  logic          want;

  assign out_instr = mem[pc];
  assign want      = run && !stopped;
  assign out_valid = want && !is_stop(out_instr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      stopped <= 1'b0;
    end else if (want) begin
      if (is_stop(out_instr)) begin
        stopped <= 1'b1;
      end else if (accept) begin
        pc <= pc + AW'(1);
        if (pc == AW'(DEPTH - 1)) stopped <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vlx_regfile.sv
module vlx_regfile import vlx_pkg::*; #(
  parameter int XLEN = 16,
  parameter int NRD  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [RW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][RW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);

  logic [NREG-1:0][XLEN-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) regs <= '0;
    else if (we) regs[waddr] <= wdata;
  end

  // write-through: a read in the write cycle returns the incoming value
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (we && waddr == raddr[g]) ? wdata : regs[raddr[g]];
  end

endmodule

// File: rtl/vlx_exec.sv
module vlx_exec import vlx_pkg::*; #(
  parameter int XLEN    = 16,
  parameter int LAT_ADD = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 6,
  localparam int LMAX = (LAT_DIV > LAT_MUL) ?
                        ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD) :
                        ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD),
  localparam int LW = (LMAX > 1) ? $clog2(LMAX) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      in_op,
  input  logic [RW-1:0]   in_rd,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            busy,
  output logic            done,
  output logic            free,
  output logic [RW-1:0]   out_rd,
  output logic [XLEN-1:0] out_val
);

  logic [2:0]      op_q;
  logic [XLEN-1:0] a_q, b_q;
  logic [LW-1:0]   cnt;

  function automatic logic [LW-1:0] hold_cycles(input logic [2:0] op);
    case (op)
      OP_MUL:  return LW'(LAT_MUL - 1);
      OP_DIV:  return LW'(LAT_DIV - 1);
      default: return LW'(LAT_ADD - 1);
    endcase
  endfunction

  assign done = busy && (cnt == '0);
  assign free = !busy || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= hold_cycles(in_op);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      op_q   <= in_op;
      out_rd <= in_rd;
      a_q    <= in_a;
      b_q    <= in_b;
    end
  end

  // operands are held for the whole residency; the result is a multicycle path
  always_comb begin
    case (op_q)
      OP_ADD:  out_val = a_q + b_q;
      OP_SUB:  out_val = a_q - b_q;
      OP_MUL:  out_val = a_q * b_q;
      default: out_val = (b_q == '0) ? '1 : a_q / b_q;
    endcase
  end

endmodule

// File: rtl/vlx_pipe.sv
module vlx_pipe import vlx_pkg::*; #(
  parameter int XLEN       = 16,
  parameter int IMEM_DEPTH = 32,
  parameter int CNT_W      = 32,
  parameter int LAT_ADD    = 1,
  parameter int LAT_MUL    = 3,
  parameter int LAT_DIV    = 6,
  localparam int AW = $clog2(IMEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_to_rf,
  input  logic [AW-1:0]    ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  input  logic             run,
  output logic             ret_valid,
  output logic [RW-1:0]    ret_rd,
  output logic [XLEN-1:0]  ret_data,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic             drained
);

  localparam int NSRC = 2;

  // stage occupancy and contents
  logic          id_v, of_v, wb_v;
  logic [IW-1:0] id_w;
  dec_t          of_d;
  logic [RW-1:0]   wb_rd;
  logic [XLEN-1:0] wb_val;

  // handshakes between stages
  logic f_valid, halted;
  logic [IW-1:0] f_instr;
  logic of_go, of_take, id_take;
  logic ex_busy, ex_done, ex_free;
  logic [RW-1:0]   ex_rd;
  logic [XLEN-1:0] ex_val;

  // load port
  logic ld_fire;
  assign ld_ready = !run && !wb_v;
  assign ld_fire  = ld_valid && ld_ready;

  assign of_go   = of_v && ex_free;
  assign of_take = !of_v || of_go;
  assign id_take = !id_v || of_take;

  vlx_fetch #(.DEPTH(IMEM_DEPTH)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ld_fire && !ld_to_rf),
    .wr_addr   (ld_addr),
    .wr_data   (ld_data[IW-1:0]),
    .run       (run),
    .accept    (id_take),
    .out_valid (f_valid),
    .out_instr (f_instr),
    .stopped   (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) id_v <= 1'b0;
    else if (id_take) id_v <= f_valid;
  end
  always_ff @(posedge clk) begin
    if (id_take) id_w <= f_instr;
  end

  always_ff @(posedge clk) begin
    if (rst) of_v <= 1'b0;
    else if (of_take) of_v <= id_v;
  end
  always_ff @(posedge clk) begin
    if (of_take) of_d <= decode(id_w);
  end

  // register file: write-back has the port, loads use it only when idle
  logic [NSRC-1:0][RW-1:0]   src;
  logic [NSRC-1:0][XLEN-1:0] rf_q, opnd;
  logic            rf_we;
  logic [RW-1:0]   rf_wa;
  logic [XLEN-1:0] rf_wd;

  assign rf_we = wb_v || (ld_fire && ld_to_rf);
  assign rf_wa = wb_v ? wb_rd  : ld_addr[RW-1:0];
  assign rf_wd = wb_v ? wb_val : ld_data;
  assign src[0] = of_d.rs1;
  assign src[1] = of_d.rs2;

  vlx_regfile #(.XLEN(XLEN), .NRD(NSRC)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_wa),
    .wdata (rf_wd),
    .raddr (src),
    .rdata (rf_q)
  );

  // the finishing execute result is the youngest producer; write-back
  // (through the write-through read) is the next one
  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    assign opnd[g] = (ex_done && ex_rd == src[g]) ? ex_val : rf_q[g];
  end

  vlx_exec #(
    .XLEN(XLEN), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_ex (
    .clk     (clk),
    .rst     (rst),
    .start   (of_go),
    .in_op   (of_d.op),
    .in_rd   (of_d.rd),
    .in_a    (opnd[0]),
    .in_b    (opnd[1]),
    .busy    (ex_busy),
    .done    (ex_done),
    .free    (ex_free),
    .out_rd  (ex_rd),
    .out_val (ex_val)
  );

  always_ff @(posedge clk) begin
    if (rst) wb_v <= 1'b0;
    else wb_v <= ex_done;
  end
  always_ff @(posedge clk) begin
    if (ex_done) begin
      wb_rd  <= ex_rd;
      wb_val <= ex_val;
    end
  end

  assign ret_valid = wb_v;
  assign ret_rd    = wb_rd;
  assign ret_data  = wb_val;

  always_ff @(posedge clk) begin
    if (rst) cycle_cnt <= '0;
    else cycle_cnt <= cycle_cnt + CNT_W'(1);
  end

  assign drained = halted && !id_v && !of_v && !ex_busy && !wb_v;

endmodule

// File: rtl/vlx_pipe_chk.sv
module vlx_pipe_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ld_ready,
  input logic             ret_valid,
  input logic             ex_busy,
  input logic             ex_done,
  input logic             ex_free,
  input logic             of_v,
  input logic             drained,
  input logic [CNT_W-1:0] cycle_cnt
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (rst || !armed)
    run |-> !ld_ready); // R11
  AST_EX_KEEPS: assert property (@(posedge clk) disable iff (rst || !armed)
    (ex_busy && !ex_done) |=> ex_busy); // R2
  AST_OF_WAITS: assert property (@(posedge clk) disable iff (rst || !armed)
    (of_v && !ex_free) |=> of_v); // R2
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (rst || !armed)
    ex_done |=> ret_valid); // R8
  AST_DRAIN_STICKY: assert property (@(posedge clk) disable iff (rst || !armed)
    drained |=> drained); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> cycle_cnt == '0); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> cycle_cnt == $past(cycle_cnt) + CNT_W'(1)); // R10

endmodule

bind vlx_pipe vlx_pipe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .ld_ready  (ld_ready),
  .ret_valid (ret_valid),
  .ex_busy   (ex_busy),
  .ex_done   (ex_done),
  .ex_free   (ex_free),
  .of_v      (of_v),
  .drained   (drained),
  .cycle_cnt (cycle_cnt)
);

// File: tb/test_vlx_pipe.sv
`timescale 1ns/1ps
module test_vlx_pipe;

  localparam int XLEN = 16;
  localparam int AW   = 5;
  localparam int CNT_W = 32;
  localparam logic [15:0] HALT = 16'hE000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_to_rf = 1'b0, run = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [XLEN-1:0] ld_data = '0;
  logic ld_ready, ret_valid, drained;
  logic [2:0] ret_rd;
  logic [XLEN-1:0] ret_data;
  logic [CNT_W-1:0] cycle_cnt;

  always #2 clk = ~clk;

  vlx_pipe i_vlx_pipe (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_to_rf(ld_to_rf), .ld_addr(ld_addr), .ld_data(ld_data), .run(run),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_data(ret_data),
    .cycle_cnt(cycle_cnt), .drained(drained)
  );

  int nchk = 0, nfail = 0;
  int nret;
  int r_rd [16];
  int r_val [16];
  int r_t [16];
  bit saw_ready_in_run;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rd, input int a, input int b);
    return {3'(op), 2'b00, 3'(rd), 1'b0, 3'(a), 1'b0, 3'(b)};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run = 1'b0; ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_word(input bit to_rf, input int addr, input logic [15:0] data);
    @(negedge clk);
    ld_valid = 1'b1; ld_to_rf = to_rf; ld_addr = AW'(addr); ld_data = data;
    @(posedge clk);
    while (!ld_ready) @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // runs until drained; a poke offers a register load during the run
  task automatic run_prog(input bit poke);
    int c0;
    @(negedge clk);
    run = 1'b1;
    c0 = int'(cycle_cnt);
    nret = 0;
    saw_ready_in_run = 1'b0;
    if (poke) begin
      ld_valid = 1'b1; ld_to_rf = 1'b1; ld_addr = AW'(2); ld_data = 16'hAAAA;
    end
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ld_ready) saw_ready_in_run = 1'b1;
      if (ret_valid) begin
        if (nret < 16) begin
          r_rd[nret] = int'(ret_rd); r_val[nret] = int'(ret_data);
          r_t[nret] = int'(cycle_cnt) - c0;
        end
        nret++;
      end
      if (drained) break;
    end
    chk(drained, "R9 drained after program", int'(drained), 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ret_valid) nret++;
    end
    ld_valid = 1'b0;
    run = 1'b0;
  endtask

  task automatic expect_ret(input int i, input int rd, input int val, input int t, input string tag);
    chk(r_rd[i] == rd, {tag, " rd"}, r_rd[i], rd);
    chk(r_val[i] == val, {tag, " value"}, r_val[i], val);
    if (t >= 0) chk(r_t[i] == t, {tag, " retire cycle"}, r_t[i], t);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cycle_cnt == 0, "R10 counter held at zero in reset", int'(cycle_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cycle_cnt == 1, "R10 counter steps after reset", int'(cycle_cnt), 1);
    chk(!ret_valid, "R8 no retire after reset", int'(ret_valid), 0);
    chk(ld_ready, "R11 load ready while stopped", int'(ld_ready), 1);
  endtask

  task automatic t_single();
    do_reset();
    load_word(1, 1, 16'd5); load_word(1, 2, 16'd7);
    load_word(0, 0, enc(0, 3, 1, 2)); load_word(0, 1, HALT);
    run_prog(0);
    chk(nret == 1, "R8 single retire count", nret, 1);
    expect_ret(0, 3, 12, 4, "R1 R3 single ADD");
  endtask

  task automatic t_mixed();
    do_reset();
    load_word(1, 1, 16'hFFF0); load_word(1, 2, 16'h0025);
    load_word(0, 0, enc(0, 3, 1, 2));
    load_word(0, 1, enc(1, 4, 2, 1));
    load_word(0, 2, enc(2, 5, 1, 2));
    load_word(0, 3, enc(3, 6, 1, 2));
    load_word(0, 4, enc(3, 7, 2, 0));
    load_word(0, 5, HALT);
    run_prog(0);
    chk(nret == 5, "R8 mixed retire count", nret, 5);
    expect_ret(0, 3, 16'h0015, 4, "R3 ADD wrap");
    expect_ret(1, 4, 16'h0035, 5, "R3 SUB wrap");
    expect_ret(2, 5, 16'hFDB0, 8, "R2 R3 MUL low half");
    expect_ret(3, 6, 16'h06EA, 14, "R2 R3 DIV quotient");
    expect_ret(4, 7, 16'hFFFF, 20, "R4 DIV by zero");
  endtask

  task automatic t_chain();
    do_reset();
    load_word(1, 1, 16'd3);
    load_word(0, 0, enc(0, 2, 1, 1));
    load_word(0, 1, enc(0, 3, 2, 1));
    load_word(0, 2, enc(0, 4, 3, 2));
    load_word(0, 3, enc(1, 5, 4, 3));
    load_word(0, 4, HALT);
    run_prog(0);
    chk(nret == 4, "R5 chain retire count", nret, 4);
    expect_ret(0, 2, 6, 4, "R5 chain 0");
    expect_ret(1, 3, 9, 5, "R5 chain 1");
    expect_ret(2, 4, 15, 6, "R5 chain 2");
    expect_ret(3, 5, 6, 7, "R5 chain 3");
  endtask

  task automatic t_priority();
    do_reset();
    load_word(1, 2, 16'd1); load_word(1, 3, 16'd2);
    load_word(1, 4, 16'd10); load_word(1, 5, 16'd20);
    load_word(0, 0, enc(0, 1, 2, 3));
    load_word(0, 1, enc(0, 1, 4, 5));
    load_word(0, 2, enc(0, 6, 1, 1));
    load_word(0, 3, enc(0, 7, 1, 0));
    load_word(0, 4, HALT);
    run_prog(0);
    chk(nret == 4, "R6 retire count", nret, 4);
    expect_ret(2, 6, 60, 6, "R6 youngest producer");
    expect_ret(3, 7, 30, 7, "R6 after overwrite");
  endtask

  task automatic t_reference();
    do_reset();
    load_word(1, 0, 16'd3); load_word(1, 1, 16'd4); load_word(1, 3, 16'd100);
    load_word(1, 4, 16'd7); load_word(1, 6, 16'd5);
    load_word(0, 0, enc(2, 2, 0, 1));
    load_word(0, 1, enc(3, 5, 3, 4));
    load_word(0, 2, enc(0, 2, 5, 2));
    load_word(0, 3, enc(1, 5, 2, 6));
    load_word(0, 4, HALT);
    run_prog(0);
    chk(nret == 4, "R7 retire count", nret, 4);
    expect_ret(0, 2, 12, 6, "R7 MUL");
    expect_ret(1, 5, 14, 12, "R7 DIV");
    expect_ret(2, 2, 26, 13, "R7 ADD");
    expect_ret(3, 5, 21, 14, "R7 SUB last write-back");
  endtask

  task automatic t_halt_and_load();
    do_reset();
    load_word(1, 2, 16'd4); load_word(1, 3, 16'd9); load_word(1, 4, 16'd3);
    load_word(0, 0, enc(3, 5, 3, 4));
    load_word(0, 1, enc(0, 6, 2, 2));
    load_word(0, 2, HALT);
    load_word(0, 3, enc(0, 7, 2, 2));
    run_prog(1);
    chk(nret == 2, "R9 nothing after halt retires", nret, 2);
    chk(!saw_ready_in_run, "R11 ready low while running", int'(saw_ready_in_run), 0);
    expect_ret(0, 5, 3, -1, "R9 DIV before halt");
    expect_ret(1, 6, 8, -1, "R11 load ignored while running");
  endtask

  initial begin
    t_reset();
    t_single();
    t_mixed();
    t_chain();
    t_priority();
    t_reference();
    t_halt_and_load();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule